// File: doc/BRIEF.md
# Next-Line Prefetch Controller

This block sits next to a cache and decides, on each demand reference, whether to ask for the next sequential line. Software or a configuration strap selects one of three policies while the block runs. The first policy issues on every reference. The second issues only when a reference misses. The third, tagged, keeps one bit per cache line. A line that arrives through prefetch starts with its bit clear, and the first demand hit on that line sets the bit and requests the line after it.

Requests pass through a small queue with a ready/valid handshake toward the memory side. A request whose target equals the previously queued target is discarded. When the queue is full, a new request is dropped, so the processor is never held up. The requested line address is the referenced line plus one, and it wraps around at the top of the address space. The cache data array and the fetch engine are outside this block.

Top module: `nlp_ctrl`

## Requirements
- R1: After reset the queue is empty (`pf_valid_o` low) and every per-line tag bit is one, so a tagged-mode hit on any line issues nothing.
- R2: With `mode_i` = 2'b00 (always), every valid reference queues a request for `ref_line_i + 1`, whether it hits or misses.
- R3: With `mode_i` = 2'b01 (on miss), only a reference with `ref_hit_i` low queues a request, and a hit queues none.
- R4: With `mode_i` = 2'b10 (tagged), a fill with `fill_pref_i` high clears the bit of line index `fill_line_i[IDX_W-1:0]`. The first hit on that line then queues `line + 1`, and a second hit queues nothing.
- R5: In tagged mode a miss queues `line + 1`, and a fill with `fill_pref_i` low sets the line's bit to one, so a later hit issues nothing.
- R6: With `mode_i` = 2'b11 (off), no request is queued.
- R7: A request whose target equals the most recently queued target is discarded.
- R8: When the queue holds `Q_DEPTH` entries, a new request is dropped and no earlier entry changes.
- R9: The target wraps modulo 2^`ADDR_W`: a reference to the all-ones line requests line zero.
- R10: Queue entries leave in the order they were queued. While `pf_valid_o` is high and `pf_ready_i` is low, the head entry stays unchanged.
- R11: If a fill and a hit hit the same line index in one cycle, the fill decides the bit's new value. The hit's trigger still uses the bit's value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 00 always, 01 on miss, 10 tagged, 11 off |
| ref_valid_i | input | 1 | Demand reference strobe |
| ref_line_i | input | ADDR_W | Line address of the reference |
| ref_hit_i | input | 1 | Reference hit in the cache |
| fill_valid_i | input | 1 | Fill of a line completed |
| fill_line_i | input | ADDR_W | Line address of the fill |
| fill_pref_i | input | 1 | The fill was brought in by prefetch |
| pf_valid_o | output | 1 | Request queue head is valid |
| pf_line_o | output | ADDR_W | Line address to prefetch |
| pf_ready_i | input | 1 | Consumer accepts the head request |

## Verification
The assertions check on every cycle the rules that hold locally. The off and on-miss policies stay quiet when they should. A request can only come from a valid reference. Tag bits take the value that a hit or a fill dictates. The queue never overfills, and its head holds steady under backpressure. Effects that span several events can only be shown by the bench's scenarios and its cycle-accurate queue model. These are the first-use trigger of a prefetched line, the duplicate filter, drops when the queue is full, address wrap, drain order, and fill priority on a shared index.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  typedef enum logic [1:0] {
    PF_ALWAYS  = 2'b00,
    PF_ON_MISS = 2'b01,
    PF_TAGGED  = 2'b10,
    PF_OFF     = 2'b11
  } pf_mode_e;
endpackage

// File: rtl/nlp_tag_array.sv
module nlp_tag_array #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_pref
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] tag_q;
  logic [LINES-1:0] tag_d;
  logic             tag_en;

  assign rd_bit = tag_q[rd_idx];
  assign tag_en = set_en | fill_en;

  // A hit marks the line as used; a fill written in the same cycle overrides it.
  always_comb begin
    tag_d = tag_q;
    if (set_en) begin
      tag_d[set_idx] = 1'b1;
    end
    if (fill_en) begin
      tag_d[fill_idx] = ~fill_pref;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '1;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  AST_PREF_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_pref) |=> !tag_q[$past(fill_idx)]) else $error("prefetched fill left tag set"); // R4
  AST_DEMAND_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !fill_pref) |=> tag_q[$past(fill_idx)]) else $error("demand fill left tag clear"); // R5
  AST_HIT_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(fill_en && fill_idx == set_idx)) |=> tag_q[$past(set_idx)]) else $error("hit did not set tag"); // R4
endmodule

// File: rtl/nlp_trigger.sv
module nlp_trigger
  import nlp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pf_mode_e          mode,
  input  logic              ref_valid,
  input  logic [ADDR_W-1:0] ref_line,
  input  logic              ref_hit,
  input  logic              tag_bit,
  input  logic              fifo_full,
  output logic              push,
  output logic [ADDR_W-1:0] push_line
);
  logic              fire;
  logic              dup;
  logic [ADDR_W-1:0] target;
  logic              last_vld_q;
  logic              last_vld_d;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W-1:0] last_d;

  always_comb begin
    unique case (mode)
      PF_ALWAYS:  fire = ref_valid;
      PF_ON_MISS: fire = ref_valid & ~ref_hit;
      PF_TAGGED:  fire = ref_valid & (~ref_hit | ~tag_bit);
      default:    fire = 1'b0;
    endcase
  end

  assign target    = ref_line + ADDR_W'(1);
  assign dup       = last_vld_q && (last_q == target);
  assign push      = fire & ~dup & ~fifo_full;
  assign push_line = target;

  always_comb begin
    last_vld_d = last_vld_q;
    last_d     = last_q;
    if (push) begin
      last_vld_d = 1'b1;
      last_d     = target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q <= 1'b0;
      last_q     <= '0;
    end else if (push) begin
      last_vld_q <= last_vld_d;
      last_q     <= last_d;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PF_OFF) |-> !push) else $error("request while off"); // R6
  AST_MISS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PF_ON_MISS && ref_hit) |-> !push) else $error("hit queued in miss mode"); // R3
  AST_PUSH_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ref_valid) else $error("request without reference"); // R2
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !(push && push_line == $past(push_line))) else $error("duplicate queued"); // R7
endmodule

// File: rtl/nlp_req_fifo.sv
module nlp_req_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign pop       = out_valid & out_ready;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = bump(wr_q);
    end
    if (pop) begin
      rd_d = bump(rd_q);
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push | pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        mem_q[g] <= push_data;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)) else $error("queue overflow"); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("head changed under backpressure"); // R10
endmodule

// File: rtl/nlp_ctrl.sv
module nlp_ctrl
  import nlp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              ref_valid_i,
  input  logic [ADDR_W-1:0] ref_line_i,
  input  logic              ref_hit_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_line_i,
  input  logic              fill_pref_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_line_o,
  input  logic              pf_ready_i
);
  logic              tag_bit;
  logic              q_full;
  logic              q_push;
  logic [ADDR_W-1:0] q_line;
  logic              unused_hi;
  pf_mode_e          mode;

  assign mode      = pf_mode_e'(mode_i);
  assign unused_hi = ^{ref_line_i[ADDR_W-1:IDX_W], fill_line_i[ADDR_W-1:IDX_W]};

  nlp_tag_array #(.IDX_W(IDX_W)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (ref_line_i[IDX_W-1:0]),
    .rd_bit    (tag_bit),
    .set_en    (ref_valid_i & ref_hit_i),
    .set_idx   (ref_line_i[IDX_W-1:0]),
    .fill_en   (fill_valid_i),
    .fill_idx  (fill_line_i[IDX_W-1:0]),
    .fill_pref (fill_pref_i)
  );

  nlp_trigger #(.ADDR_W(ADDR_W)) trig_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ref_valid (ref_valid_i),
    .ref_line  (ref_line_i),
    .ref_hit   (ref_hit_i),
    .tag_bit   (tag_bit),
    .fifo_full (q_full),
    .push      (q_push),
    .push_line (q_line)
  );

  nlp_req_fifo #(.W(ADDR_W), .DEPTH(Q_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (q_line),
    .full      (q_full),
    .out_valid (pf_valid_o),
    .out_data  (pf_line_o),
    .out_ready (pf_ready_i)
  );

  AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && ref_line_i == '1) |-> (q_line == '0)) else $error("target did not wrap"); // R9
endmodule

// File: tb/nlp_ctrl_tb_top.sv
module nlp_ctrl_tb_top;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 4;
  localparam int MASK   = (1 << ADDR_W) - 1;

  logic              clk;
  logic              rst_n;
  logic [1:0]        mode_i;
  logic              ref_valid_i;
  logic [ADDR_W-1:0] ref_line_i;
  logic              ref_hit_i;
  logic              fill_valid_i;
  logic [ADDR_W-1:0] fill_line_i;
  logic              fill_pref_i;
  logic              pf_valid_o;
  logic [ADDR_W-1:0] pf_line_o;
  logic              pf_ready_i;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R1";

  int q[$];
  bit m_tag [1 << IDX_W];
  bit m_last_vld;
  int m_last;

  nlp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .Q_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .ref_valid_i(ref_valid_i), .ref_line_i(ref_line_i), .ref_hit_i(ref_hit_i),
    .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i), .fill_pref_i(fill_pref_i),
    .pf_valid_o(pf_valid_o), .pf_line_o(pf_line_o), .pf_ready_i(pf_ready_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      foreach (m_tag[i]) m_tag[i] = 1'b1;
      m_last_vld = 1'b0;
      m_last = 0;
    end else begin
      bit fire;
      bit full;
      int tgt;
      int ri;
      int fi;
      ri = int'(ref_line_i) % (1 << IDX_W);
      fi = int'(fill_line_i) % (1 << IDX_W);
      full = (q.size() >= DEPTH);
      tgt = (int'(ref_line_i) + 1) & MASK;
      case (mode_i)
        2'b00: fire = ref_valid_i;
        2'b01: fire = ref_valid_i && !ref_hit_i;
        2'b10: fire = ref_valid_i && (!ref_hit_i || !m_tag[ri]);
        default: fire = 1'b0;
      endcase
      if (q.size() > 0 && pf_ready_i) void'(q.pop_front());
      if (fire && !(m_last_vld && m_last == tgt) && !full) begin
        q.push_back(tgt);
        m_last_vld = 1'b1;
        m_last = tgt;
      end
      if (ref_valid_i && ref_hit_i) m_tag[ri] = 1'b1;
      if (fill_valid_i) m_tag[fi] = !fill_pref_i;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare against the model away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, int'(pf_valid_o), int'(q.size() != 0), "pf_valid_o");
      if (q.size() != 0 && pf_valid_o) check(cur_req, int'(pf_line_o), q[0], "pf_line_o");
    end
  end

  task automatic cyc(input bit rv, input int line, input bit hit,
                     input bit fv, input int fl, input bit fp);
    @(negedge clk);
    ref_valid_i  = rv;
    ref_line_i   = ADDR_W'(line);
    ref_hit_i    = hit;
    fill_valid_i = fv;
    fill_line_i  = ADDR_W'(fl);
    fill_pref_i  = fp;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL ALL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    mode_i = 2'b10;
    pf_ready_i = 1'b1;
    ref_valid_i = 0; ref_line_i = '0; ref_hit_i = 0;
    fill_valid_i = 0; fill_line_i = '0; fill_pref_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(pf_valid_o), 0, "pf_valid_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(pf_valid_o), 0, "pf_valid_o after reset");

    // R1: tag bits are one after reset, so tagged hits issue nothing
    cur_req = "R1";
    for (int i = 0; i < 16; i++) cyc(1, i, 1, 0, 0, 0);
    idle(2);
    check("R1", int'(pf_valid_o), 0, "tagged hits after reset");

    // R2: always mode
    cur_req = "R2"; mode_i = 2'b00;
    cyc(1, 'h100, 1, 0, 0, 0);
    cyc(1, 'h200, 0, 0, 0, 0);
    cyc(1, 'h300, 1, 0, 0, 0);
    idle(4);

    // R3: on-miss mode
    cur_req = "R3"; mode_i = 2'b01;
    cyc(1, 'h400, 1, 0, 0, 0);
    @(negedge clk);
    check("R3", int'(pf_valid_o), 0, "hit in miss mode");
    cyc(1, 'h500, 0, 0, 0, 0);
    @(negedge clk);
    check("R3", int'(pf_line_o), 'h501, "miss target");
    idle(3);

    // R4: prefetched line triggers on first hit only
    cur_req = "R4"; mode_i = 2'b10;
    cyc(0, 0, 0, 1, 'h21, 1);
    cyc(1, 'h21, 1, 0, 0, 0);
    @(negedge clk);
    check("R4", int'(pf_line_o), 'h22, "first use target");
    cyc(1, 'h21, 1, 0, 0, 0);
    cyc(1, 'h80, 0, 0, 0, 0);
    cyc(1, 'h21, 1, 0, 0, 0);
    idle(3);

    // R5: demand miss triggers, demand fill sets tag
    cur_req = "R5";
    cyc(1, 'h30, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 'h30, 0);
    cyc(1, 'h90, 0, 0, 0, 0);
    cyc(1, 'h30, 1, 0, 0, 0);
    idle(3);

    // R6: off mode
    cur_req = "R6"; mode_i = 2'b11;
    cyc(1, 'h600, 0, 0, 0, 0);
    cyc(1, 'h610, 1, 0, 0, 0);
    idle(2);
    check("R6", int'(pf_valid_o), 0, "off mode quiet");

    // R7: duplicate suppression
    cur_req = "R7"; mode_i = 2'b00;
    cyc(1, 'h40, 1, 0, 0, 0);
    cyc(1, 'h40, 1, 0, 0, 0);
    cyc(1, 'h41, 1, 0, 0, 0);
    cyc(1, 'h40, 1, 0, 0, 0);
    idle(4);

    // R8 and R10: full queue drops, order kept under backpressure
    cur_req = "R8"; pf_ready_i = 1'b0;
    for (int i = 0; i < 5; i++) cyc(1, 'h70 + 2 * i, 0, 0, 0, 0);
    idle(2);
    check("R8", int'(pf_line_o), 'h71, "head held while full");
    cur_req = "R10";
    @(negedge clk); pf_ready_i = 1'b1;
    idle(6);

    // R9: wrap
    cur_req = "R9";
    cyc(1, MASK, 1, 0, 0, 0);
    @(negedge clk);
    check("R9", int'(pf_line_o), 0, "wrapped target");
    idle(2);

    // R11: fill overrides hit on the same index
    cur_req = "R11"; mode_i = 2'b10;
    cyc(0, 0, 0, 1, 'h52, 1);
    cyc(1, 'h52, 1, 1, 'h52, 1);
    cyc(1, 'hA0, 0, 0, 0, 0);
    cyc(1, 'h52, 1, 0, 0, 0);
    idle(4);

    // R10: mixed traffic with random backpressure
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      mode_i       = 2'($urandom_range(0, 3));
      pf_ready_i   = 1'($urandom_range(0, 1));
      ref_valid_i  = 1'($urandom_range(0, 1));
      ref_line_i   = ADDR_W'($urandom_range(0, 40));
      ref_hit_i    = 1'($urandom_range(0, 1));
      fill_valid_i = 1'($urandom_range(0, 1));
      fill_line_i  = ADDR_W'($urandom_range(0, 40));
      fill_pref_i  = 1'($urandom_range(0, 1));
      @(posedge clk);
    end
    @(negedge clk); pf_ready_i = 1'b1;
    idle(8);
    finish_run();
  end
endmodule